// File: doc/BRIEF.md
# Seven-Level Trapezoid-Reference PWM Modulator

This block turns a free-running phase into the level command for a seven-level inverter leg. A phase counter sweeps one fundamental period. From that phase the block builds a triangle, flattens it at a programmable plateau to get a trapezoid, and compares the trapezoid against six stacked carriers. Each carrier is an inverted half sine and fills one band of unit height. Three bands sit above zero and three below. All six carriers share one waveform and one phase; only their offset differs. Each comparison gives one command bit, and the bits combine into a signed level from −3 to +3.

The carriers come from a 64-entry quarter-wave sine table. The table is computed from a rational sine formula when the design is elaborated, so no table file is needed. Comparisons run at twice the band resolution: carriers always land on odd codes and the reference on even codes, so the two can never be equal. Parameters set the number of carrier cycles per fundamental, the modulation index and the plateau level.

The six raw command bits and the level both leave through one output register. A downstream stage maps the level onto gate signals and adds dead time.

Top module: `pdm_modulator`

## Requirements
- R1: While `rst_n` is low, the block returns to phase 0 with `level_o` = 0 and `cmd_o` = 6'b111000, which is the zero-reference code.
- R2: Sine table entry k (0..63) is floor(4095·16q / (327680 − 4q)) with q = (2k+1)(255−2k). Carrier index i = phase mod 128 reads entry i when i < 64 and entry 127−i otherwise.
- R3: Carriers are at double scale. The upper carrier of band b (0..2) is 8192b + 8191 − 2s, and the lower carrier of band b is its negation. `cmd_o[b]` is set when the reference is strictly above upper carrier b. `cmd_o[3+b]` is set when the reference is strictly above lower carrier b.
- R4: The phase counts 0..P−1 and then wraps, with P = 128·CARRIER_RATIO and Q = P/4. The constants are A = floor(12288·MOD_INDEX_PM/1000), K = floor(A·65536/Q) and L = floor(A·CLIP_PM/1000). Define m = phase mod 2Q, x = m if m ≤ Q else 2Q − m, and mag = min(floor(x·K/65536), L). The reference is 2·mag, negated when phase ≥ 2Q.
- R5: `level_o` equals the number of set upper bits minus the number of clear lower bits. It never leaves −3..+3.
- R6: The outputs sampled after the n-th rising edge following reset release reflect phase n−1. There is exactly one register between the phase and the outputs.
- R7: With an even CARRIER_RATIO, the level at phase p + 2Q is the negation of the level at phase p, for every p in the first half period.
- R8: The command bits fill like a thermometer. Upper bits fill from band 0 upward. Each lower bit implies the lower bits of higher-numbered bands. Any set upper bit implies that all lower bits are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one phase step per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| level_o | output | 3 | Signed output level, −3..+3 |
| cmd_o | output | 6 | Raw comparator bits: [2:0] upper bands 0..2, [5:3] lower bands 0..2 |

## Verification
The modulator is driven by its own phase, so the input patterns are parameter sets and points in the phase sweep. The default instance runs a full fundamental with the plateau active, and a fixed-point model predicts every sample; a one-cycle latency error or a mirrored table fails there. A second instance uses half the modulation index, no clipping and a shorter period, which separates slope and scaling faults from plateau faults. Hand-worked points at the zero crossing, the peak and the plateau pin down the band offsets, and a half-period comparison of the observed levels exposes any asymmetry between the upper and lower bands.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

    // Sine table geometry
    localparam int SIN_BITS  = 12;
    localparam int LUT_DEPTH = 64;
    localparam int LUT_AW    = $clog2(LUT_DEPTH);
    localparam int CIDX_W    = LUT_AW + 1;          // index over half a sine period
    localparam int HALF_SINE = 2 * LUT_DEPTH;       // samples per carrier cycle

    // Band stack
    localparam int NBANDS  = 3;
    localparam int BAND_H  = 2 ** SIN_BITS;         // one band in single scale
    localparam int CMD_W   = 2 * NBANDS;
    localparam int LVL_W   = $clog2(NBANDS + 1) + 1;
    localparam int SMP_W   = 16;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic [LUT_DEPTH-1:0][SIN_BITS-1:0] sine_lut_t;

    // Rational sine approximation at half-sample offsets (k + 0.5) / (4 * depth) of a turn,
    // computed at elaboration so the table mirrors exactly about its peak.
    function automatic sine_lut_t build_sine_lut();
        sine_lut_t tbl;
        longint    n2;
        longint    q;
        n2 = longint'(4 * LUT_DEPTH);
        for (int k = 0; k < LUT_DEPTH; k++) begin
            q      = longint'(2 * k + 1) * (n2 - 1 - longint'(2 * k));
            tbl[k] = SIN_BITS'((longint'(BAND_H - 1) * 16 * q) / (5 * n2 * n2 - 4 * q));
        end
        return tbl;
    endfunction

endpackage

// File: rtl/pdm_trap_ref.sv
module pdm_trap_ref
    import pdm_pkg::*;
#(
    parameter int RATIO   = 40,
    parameter int MI_PM   = 1000,
    parameter int CLIP_PM = 800,
    parameter int PH_W    = 13
) (
    input  logic [PH_W-1:0] ph_i,
    output smp_t            trap_o
);
    localparam int PER   = HALF_SINE * RATIO;
    localparam int HALF  = PER / 2;
    localparam int QTR   = PER / 4;
    localparam int AMP   = NBANDS * BAND_H * MI_PM / 1000;
    localparam int SLOPE = int'((longint'(AMP) * 65536) / longint'(QTR));
    localparam int LIM   = AMP * CLIP_PM / 1000;

    logic            neg;
    logic [PH_W-1:0] m;
    logic [PH_W-1:0] x;
    logic [47:0]     prod;
    smp_t            ramp;
    smp_t            mag;

    always_comb begin
        neg    = (ph_i >= PH_W'(HALF));
        m      = neg ? (ph_i - PH_W'(HALF)) : ph_i;
        x      = (m <= PH_W'(QTR)) ? m : (PH_W'(HALF) - m);
        prod   = 48'(x) * 48'(SLOPE);
        ramp   = smp_t'(prod >> 16);
        mag    = (ramp > smp_t'(LIM)) ? smp_t'(LIM) : ramp;
        trap_o = neg ? -(mag <<< 1) : (mag <<< 1);
    end

endmodule

// File: rtl/pdm_carrier_bank.sv
module pdm_carrier_bank
    import pdm_pkg::*;
(
    input  logic [CIDX_W-1:0]     idx_i,
    output smp_t [NBANDS-1:0]     up_o,
    output smp_t [NBANDS-1:0]     lo_o
);
    localparam sine_lut_t LUT = build_sine_lut();

    logic [LUT_AW-1:0]   addr;
    logic [SIN_BITS-1:0] s;

    // Second quarter of the half period reads the table backwards.
    assign addr = idx_i[LUT_AW] ? ~idx_i[LUT_AW-1:0] : idx_i[LUT_AW-1:0];
    assign s    = LUT[addr];

    for (genvar b = 0; b < NBANDS; b++) begin : g_band
        localparam int TOP = (2 * b + 2) * BAND_H - 1;   // odd band ceiling at double scale
        assign up_o[b] = smp_t'(TOP) - smp_t'({s, 1'b0});
        assign lo_o[b] = -up_o[b];
    end

endmodule

// File: rtl/pdm_modulator.sv
module pdm_modulator
    import pdm_pkg::*;
#(
    parameter int CARRIER_RATIO = 40,
    parameter int MOD_INDEX_PM  = 1000,
    parameter int CLIP_PM       = 800
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic signed [LVL_W-1:0] level_o,
    output logic [CMD_W-1:0]        cmd_o
);
    localparam int PERIOD = HALF_SINE * CARRIER_RATIO;
    localparam int PH_W   = $clog2(PERIOD);

    typedef struct packed {
        logic [PH_W-1:0]         ph;
        logic signed [LVL_W-1:0] level;
        logic [CMD_W-1:0]        cmd;
    } state_t;

    localparam state_t RST_ST = '{ph: '0, level: '0, cmd: {{NBANDS{1'b1}}, {NBANDS{1'b0}}}};

    state_t              st_d, st_q;
    smp_t                trap;
    smp_t [NBANDS-1:0]   car_up;
    smp_t [NBANDS-1:0]   car_lo;
    logic [CMD_W-1:0]    hit;

    pdm_trap_ref #(
        .RATIO  (CARRIER_RATIO),
        .MI_PM  (MOD_INDEX_PM),
        .CLIP_PM(CLIP_PM),
        .PH_W   (PH_W)
    ) u_ref (
        .ph_i  (st_q.ph),
        .trap_o(trap)
    );

    pdm_carrier_bank u_car (
        .idx_i(st_q.ph[CIDX_W-1:0]),
        .up_o (car_up),
        .lo_o (car_lo)
    );

    for (genvar b = 0; b < NBANDS; b++) begin : g_cmp
        assign hit[b]          = ($signed(trap) > $signed(car_up[b]));
        assign hit[NBANDS + b] = ($signed(trap) > $signed(car_lo[b]));
    end

    always_comb begin
        logic signed [LVL_W-1:0] acc;
        st_d    = st_q;
        st_d.ph = (st_q.ph == PH_W'(PERIOD - 1)) ? '0 : st_q.ph + 1'b1;
        // set upper bits add, clear lower bits subtract: sum of all set bits minus band count
        acc = LVL_W'(-NBANDS);
        for (int b = 0; b < CMD_W; b++) begin
            acc = acc + {{(LVL_W-1){1'b0}}, hit[b]};
        end
        st_d.level = acc;
        st_d.cmd   = hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;
    assign cmd_o   = st_q.cmd;

endmodule

// File: rtl/pdm_modulator_chk.sv
module pdm_modulator_chk
    import pdm_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic signed [LVL_W-1:0] level_o,
    input logic [CMD_W-1:0]        cmd_o
);
    // R1: reset leaves the zero-reference code
    p_reset_code_r1: assert property (@(posedge clk)
        !rst_n |=> (level_o == '0 && cmd_o == 6'b111000));

    // R5: the level never takes the unused most negative code
    p_level_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        level_o != 3'sb100);

    // R5: the level agrees with the bit counts it is made from
    p_level_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level_o) == $countones(cmd_o[2:0]) - (NBANDS - $countones(cmd_o[5:3])));

    // R8: upper bands fill from band 0 upward
    p_upper_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_o[2] || cmd_o[1]) && (!cmd_o[1] || cmd_o[0]));

    // R8: lower band 0 implies band 1 implies band 2
    p_lower_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_o[3] || cmd_o[4]) && (!cmd_o[4] || cmd_o[5]));

    // R8: any upper crossing means every lower carrier is passed
    p_upper_needs_lower_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|cmd_o[2:0]) || (&cmd_o[5:3]));

endmodule

bind pdm_modulator pdm_modulator_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .level_o(level_o),
    .cmd_o  (cmd_o)
);

// File: tb/tb_pdm_modulator.sv
module tb_pdm_modulator;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [2:0] lvl_a, lvl_b;
    logic [5:0] cmd_a, cmd_b;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam int PA = 128 * 40;
    localparam int PB = 128 * 4;

    always #2 clk = ~clk;   // 250 MHz

    pdm_modulator dut (.clk(clk), .rst_n(rst_n), .level_o(lvl_a), .cmd_o(cmd_a));

    pdm_modulator #(.CARRIER_RATIO(4), .MOD_INDEX_PM(500), .CLIP_PM(1000)) dut_lo (
        .clk(clk), .rst_n(rst_n), .level_o(lvl_b), .cmd_o(cmd_b));

    typedef struct packed {
        int               ph;
        logic signed [3:0] lvl;
        logic [5:0]        cmd;
    } vec_t;

    // hand-worked points of the default instance (R3, R4)
    localparam vec_t VEC [4] = '{
        '{ph: 0,    lvl:  4'sd0, cmd: 6'b111000},   // zero crossing
        '{ph: 1280, lvl:  4'sd2, cmd: 6'b111011},   // plateau, carrier trough
        '{ph: 1344, lvl:  4'sd3, cmd: 6'b111111},   // plateau, carrier peak
        '{ph: 3840, lvl: -4'sd2, cmd: 6'b100000}    // negative plateau
    };

    function automatic int sine_entry(int k);
        longint q;
        q = longint'(2 * k + 1) * longint'(255 - 2 * k);
        return int'((longint'(4095) * 16 * q) / (longint'(327680) - 4 * q));
    endfunction

    function automatic logic [5:0] model_cmd(int ph, int ratio, int mi, int clip);
        int p, qt, a, l, m, x, mag, r, i, s, c;
        longint kk;
        logic [5:0] bits;
        p  = 128 * ratio;
        qt = p / 4;
        a  = 12288 * mi / 1000;
        kk = (longint'(a) * 65536) / longint'(qt);
        l  = a * clip / 1000;
        m  = (ph >= 2 * qt) ? ph - 2 * qt : ph;
        x  = (m <= qt) ? m : 2 * qt - m;
        mag = int'((longint'(x) * kk) / 65536);
        if (mag > l) mag = l;
        r = (ph >= 2 * qt) ? -2 * mag : 2 * mag;
        i = ph % 128;
        s = (i < 64) ? sine_entry(i) : sine_entry(127 - i);
        for (int b = 0; b < 3; b++) begin
            c = 8192 * b + 8191 - 2 * s;
            bits[b]     = (r > c);
            bits[3 + b] = (r > -c);
        end
        return bits;
    endfunction

    function automatic int level_of(logic [5:0] bits);
        return $countones(bits[2:0]) - (3 - $countones(bits[5:3]));
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit thermo_ok(logic [5:0] c);
        return (!c[2] || c[1]) && (!c[1] || c[0]) && (!c[3] || c[4]) && (!c[4] || c[5])
               && (!(|c[2:0]) || (&c[5:3]));
    endfunction

    int sym_a [PA/2];
    int sym_b [PB/2];

    initial begin
        logic [5:0] e;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state on both instances
        check(lvl_a == 0 && cmd_a == 6'b111000, "R1 reset dut", int'(cmd_a), 56);
        check(lvl_b == 0 && cmd_b == 6'b111000, "R1 reset dut_lo", int'(cmd_b), 56);
        rst_n = 1'b1;

        // one full fundamental of the default instance; outputs after edge n show phase n-1
        for (int n = 0; n < PA; n++) begin
            int pb;
            @(negedge clk);
            e = model_cmd(n, 40, 1000, 800);
            check(cmd_a == e, "R2 R3 R4 R6 cmd dut", int'(cmd_a), int'(e));
            check(int'(lvl_a) == level_of(e), "R5 level dut", int'(lvl_a), level_of(e));
            check(thermo_ok(cmd_a), "R8 fill order dut", int'(cmd_a), int'(e));
            for (int v = 0; v < 4; v++) begin
                if (VEC[v].ph == n) begin
                    check(cmd_a == VEC[v].cmd, "R3 table cmd", int'(cmd_a), int'(VEC[v].cmd));
                    check(int'(lvl_a) == int'(VEC[v].lvl), "R4 table level", int'(lvl_a),
                          int'(VEC[v].lvl));
                end
            end
            if (n < PA / 2) sym_a[n] = int'(lvl_a);
            else check(int'(lvl_a) == -sym_a[n - PA / 2], "R7 symmetry dut", int'(lvl_a),
                       -sym_a[n - PA / 2]);

            pb = n % PB;
            e  = model_cmd(pb, 4, 500, 1000);
            check(cmd_b == e, "R2 R3 R4 R6 cmd dut_lo", int'(cmd_b), int'(e));
            check(int'(lvl_b) == level_of(e), "R5 level dut_lo", int'(lvl_b), level_of(e));
            if (n < PB / 2) sym_b[n] = int'(lvl_b);
            else if (n < PB) check(int'(lvl_b) == -sym_b[n - PB / 2], "R7 symmetry dut_lo",
                                   int'(lvl_b), -sym_b[n - PB / 2]);
        end

        // R1 mid-run reset, then R6 restart from phase 0
        for (int n = 0; n < 1344 - PA % 1344; n++) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(lvl_a == 0 && cmd_a == 6'b111000, "R1 reset mid-run", int'(cmd_a), 56);
        rst_n = 1'b1;
        for (int n = 0; n < 1345; n++) begin
            @(negedge clk);
            if (n == 1344) begin
                check(cmd_a == 6'b111111, "R6 restart phase 1344", int'(cmd_a), 63);
                check(int'(lvl_a) == 3, "R6 restart level", int'(lvl_a), 3);
            end
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule